// File: doc/BRIEF.md
# Pulse Position and Width Symbol Demodulator

This block receives a line code in which each symbol period carries a single pulse. The pulse's leading-edge timing carries one bit and its duration carries two more. The line is sampled on a fast tick clock that is aligned with a local symbol reference. `sym_start_i` marks the first tick of every symbol period.

The leading edge is timed against that reference to recover the position bit. From the leading edge, the block builds three delayed reference edges. The trailing edge is then graded by how many of those reference edges it comes after, which gives the two width bits.

All spacings are in half-steps of `cal_i + 1` ticks, which is the same calibration code the transmitter uses. A symbol period with no pulse, a surplus pulse, or a pulse still high when the next period begins is reported on `err_o` and yields no symbol. Clock recovery is done elsewhere.

Top module: `ppd_demod`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first event, `valid_o`, `err_o` and `sym_o` are all zero.
- R2: Let the half-step be h = `cal_i` + 1 ticks. Let d be the number of ticks from the edge where `sym_start_i` is sampled high to the edge where the line is first sampled high (d = 0 if they coincide). Then `sym_o[2]` is 0 when d < h and 1 otherwise.
- R3: Let w be the number of consecutive high samples of the pulse. Then `sym_o[1:0]` is 0 for w < 3h, 1 for 3h ≤ w < 5h, 2 for 5h ≤ w < 7h, and 3 for w ≥ 7h.
- R4: Both thresholds scale with `cal_i`, so the same pulse decodes to different fields under different calibration codes.
- R5: `valid_o` is high for exactly one cycle. That cycle follows the edge where the line is first sampled low after an accepted pulse. `sym_o` changes only in such a cycle and holds otherwise.
- R6: If a whole symbol period passes with no leading edge, `err_o` pulses for one cycle after the next `sym_start_i` edge.
- R7: A second leading edge in the same period raises `err_o` in the cycle after that edge. The extra pulse never produces `valid_o`.
- R8: If the line is still high from an accepted pulse at a `sym_start_i` edge, that pulse is dropped. `err_o` pulses in the next cycle, and the pulse's later fall produces no `valid_o`.
- R9: Line activity before the first `sym_start_i` after reset is ignored and raises neither `valid_o` nor `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, aligned to the symbol reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Received pulse line, sampled every tick |
| sym_start_i | input | 1 | High on the first tick of each symbol period |
| cal_i | input | 3 | Calibration code; half-step = cal_i + 1 ticks |
| sym_o | output | 3 | Decoded symbol {position, width[1:0]} |
| valid_o | output | 1 | One-cycle strobe marking a new sym_o |
| err_o | output | 1 | One-cycle strobe for missing, extra or overrunning pulse |

## Verification
Every result is registered once, so it appears in the cycle after the edge that caused it. `valid_o` and `sym_o` follow the edge where the line is first seen low. `err_o` follows either the `sym_start_i` edge that closes a faulty period or the edge of the surplus rise.

The bench drives inputs at the falling clock edge. It advances a requirement-level model at each rising edge and compares all outputs at the next falling edge, so each expected value is checked in the exact cycle it is due. Directed periods with literal expected symbols cover the position and width threshold boundaries under several calibration codes. Random periods cover mixed pulse placements and error cases.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
  localparam int unsigned PPD_TAPS   = 3;
  localparam int unsigned PPD_CODE_W = 2;

  typedef struct packed {
    logic                  pos;
    logic [PPD_CODE_W-1:0] width;
  } ppd_sym_t;

  // thermometer of passed reference edges -> width code
  function automatic logic [PPD_CODE_W-1:0] taps_to_code(input logic [PPD_TAPS-1:0] passed);
    logic [PPD_CODE_W-1:0] n;
    n = '0;
    for (int i = 0; i < PPD_TAPS; i++) n = n + PPD_CODE_W'(passed[i]);
    return n;
  endfunction
endpackage

// File: rtl/ppd_edge_det.sv
module ppd_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_i;
  end

  assign rise_o = line_i & ~line_q;
  assign fall_o = ~line_i & line_q;
endmodule

// File: rtl/ppd_pos_meas.sv
module ppd_pos_meas #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned HALF_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_start_i,
  input  logic              accept_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              pos_o
);
  localparam logic [CNT_W-1:0] PhaseMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] offset;
  logic             pos_q;

  // ticks since the reference edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= '0;
    else if (sym_start_i)     phase_q <= CNT_W'(1);
    else if (phase_q != PhaseMax) phase_q <= phase_q + CNT_W'(1);
  end

  assign offset = sym_start_i ? '0 : phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= 1'b0;
    else if (accept_i) pos_q <= (offset >= CNT_W'(half_i));
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/ppd_width_taps.sv
module ppd_width_taps #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned HALF_W = 4,
  parameter int unsigned TAPS   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [TAPS-1:0]   passed_o
);
  localparam int unsigned TH_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] AgeMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] age_q;

  // ticks since the leading edge; delayed copies of it form the reference edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      age_q <= '0;
    else if (start_i)                 age_q <= CNT_W'(1);
    else if (run_i && age_q != AgeMax) age_q <= age_q + CNT_W'(1);
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam int unsigned MULT = 2 * k + 3;
    logic [TH_W-1:0] thr;
    assign thr         = TH_W'(MULT) * TH_W'(half_i);
    assign passed_o[k] = {1'b0, age_q} >= thr;
  end
endmodule

// File: rtl/ppd_demod.sv
module ppd_demod
  import ppd_pkg::*;
#(
  parameter int unsigned CAL_W     = 3,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned HALF_BASE = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             sym_start_i,
  input  logic [CAL_W-1:0] cal_i,
  output logic [2:0]       sym_o,
  output logic             valid_o,
  output logic             err_o
);
  localparam int unsigned HALF_W = CAL_W + 1;

  logic [HALF_W-1:0]   half;
  logic                rise, fall;
  logic                active_q, seen_q, busy_q;
  logic                in_frame, seen_cur;
  logic                accept, dup, complete, abort, missing;
  logic                pos;
  logic [PPD_TAPS-1:0] passed;
  ppd_sym_t            sym_q;
  logic                valid_q, err_q;

  assign half = HALF_W'(cal_i) + HALF_W'(HALF_BASE);

  ppd_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign in_frame = active_q | sym_start_i;
  assign seen_cur = sym_start_i ? 1'b0 : seen_q;
  assign accept   = rise & in_frame & ~seen_cur;
  assign dup      = rise & in_frame & seen_cur;
  assign complete = fall & busy_q;
  assign abort    = sym_start_i & busy_q & line_i;
  assign missing  = sym_start_i & active_q & ~seen_q;

  ppd_pos_meas #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_pos (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_start_i (sym_start_i),
    .accept_i    (accept),
    .half_i      (half),
    .pos_o       (pos)
  );

  ppd_width_taps #(.CNT_W(CNT_W), .HALF_W(HALF_W), .TAPS(PPD_TAPS)) u_taps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .run_i    (busy_q),
    .half_i   (half),
    .passed_o (passed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      seen_q   <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      active_q <= in_frame;
      seen_q   <= accept | seen_cur;
      if (accept)                busy_q <= 1'b1;
      else if (complete | abort) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= complete;
      err_q   <= missing | abort | dup;
      if (complete) begin
        sym_q.pos   <= pos;
        sym_q.width <= taps_to_code(passed);
      end
    end
  end

  assign sym_o   = sym_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/ppd_demod_chk.sv
module ppd_demod_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_i,
  input logic       sym_start_i,
  input logic [2:0] sym_o,
  input logic       valid_o,
  input logic       err_o
);
  // R5
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R5
  valid_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(!line_i) && $past(line_i, 2)));

  // R5
  sym_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sym_o) |-> valid_o);

  // R6
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(sym_start_i) || $past(line_i)));

  // R7
  no_err_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!valid_o && !err_o && sym_o == 3'b000);
    end
  end
endmodule

bind ppd_demod ppd_demod_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_i      (line_i),
  .sym_start_i (sym_start_i),
  .sym_o       (sym_o),
  .valid_o     (valid_o),
  .err_o       (err_o)
);

// File: tb/ppd_demod_tb_top.sv
`timescale 1ns/1ps
module ppd_demod_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_i = 1'b0;
  logic       sym_start_i = 1'b0;
  logic [2:0] cal_i = 3'd0;
  logic [2:0] sym_o;
  logic       valid_o;
  logic       err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit       m_prev, m_active, m_seen, m_busy, m_pos;
  int       m_wlen, m_phase;
  bit       e_valid, e_err;
  bit [2:0] e_sym;

  int       dut_vcnt = 0, dut_ecnt = 0;
  bit [2:0] last_sym;

  always #4 clk_i = ~clk_i;

  ppd_demod dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (line_i),
    .sym_start_i (sym_start_i),
    .cal_i       (cal_i),
    .sym_o       (sym_o),
    .valid_o     (valid_o),
    .err_o       (err_o)
  );

  function automatic bit [1:0] width_code(int w, int h);
    if (w < 3 * h) return 2'd0;
    if (w < 5 * h) return 2'd1;
    if (w < 7 * h) return 2'd2;
    return 2'd3;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step(bit s, bit l);
    int  h = int'(cal_i) + 1;
    bit  rise = l && !m_prev;
    bit  fall = !l && m_prev;
    bit  busy_old = m_busy;
    bit  seen_c = s ? 1'b0 : m_seen;
    bit  acc = 1'b0;
    e_valid = 1'b0;
    e_err   = 1'b0;
    if (fall && m_busy) begin
      e_valid = 1'b1;
      e_sym   = {m_pos, width_code(m_wlen, h)};
      m_busy  = 1'b0;
    end
    if (s && m_active && !m_seen) e_err = 1'b1;
    if (s && m_busy && l) begin
      e_err  = 1'b1;
      m_busy = 1'b0;
    end
    if (rise && (m_active || s)) begin
      if (seen_c) e_err = 1'b1;
      else begin
        acc    = 1'b1;
        seen_c = 1'b1;
        m_busy = 1'b1;
        m_pos  = ((s ? 0 : m_phase) >= h);
        m_wlen = 1;
      end
    end
    if (!acc && busy_old && m_wlen < 255) m_wlen++;
    m_phase  = s ? 1 : (m_phase < 255 ? m_phase + 1 : 255);
    m_active = m_active || s;
    m_seen   = seen_c;
    m_prev   = l;
  endtask

  task automatic tick(bit s, bit l);
    sym_start_i = s;
    line_i      = l;
    @(posedge clk_i);
    model_step(s, l);
    @(negedge clk_i);
    check("R5", "valid_o", int'(valid_o), int'(e_valid));
    check("R6", "err_o", int'(err_o), int'(e_err));
    if (e_valid) begin
      check("R2", "sym_o[2]", int'(sym_o[2]), int'(e_sym[2]));
      check("R3", "sym_o[1:0]", int'(sym_o[1:0]), int'(e_sym[1:0]));
    end
    if (valid_o) begin
      dut_vcnt++;
      last_sym = sym_o;
    end
    if (err_o) dut_ecnt++;
  endtask

  // hi: line high for j < hi (carried pulse); w = 0 means no pulse
  task automatic run_period(int p, int hi, int d1, int w1, int d2, int w2);
    for (int j = 0; j < p; j++) begin
      tick(j == 0, (j < hi) || (w1 > 0 && j >= d1 && j < d1 + w1) ||
                   (w2 > 0 && j >= d2 && j < d2 + w2));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int v0, e0, hold;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1", "valid_o in reset", int'(valid_o), 0);
    check("R1", "err_o in reset", int'(err_o), 0);
    check("R1", "sym_o in reset", int'(sym_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "sym_o after reset", int'(sym_o), 0);

    // R9: activity before first reference
    v0 = dut_vcnt; e0 = dut_ecnt;
    for (int j = 0; j < 12; j++) tick(1'b0, j >= 2 && j < 8);
    check("R9", "valid before start", dut_vcnt - v0, 0);
    check("R9", "err before start", dut_ecnt - e0, 0);

    // R3: cal=2 (h=3), d=2, w=10 -> 3'b001
    cal_i = 3'd2;
    v0 = dut_vcnt;
    run_period(20, 0, 2, 10, 0, 0);
    check("R3", "valid count", dut_vcnt - v0, 1);
    check("R3", "sym h=3 d=2 w=10", int'(last_sym), 3'b001);
    // R2: d=h boundary -> pos 1, w=4 -> 3'b100
    run_period(20, 0, 3, 4, 0, 0);
    check("R2", "sym h=3 d=3 w=4", int'(last_sym), 3'b100);
    // R4: same w=10 under cal=0 -> code 3, d=0 -> pos 0
    cal_i = 3'd0;
    run_period(20, 0, 0, 10, 0, 0);
    check("R4", "sym h=1 d=0 w=10", int'(last_sym), 3'b011);
    cal_i = 3'd1;
    run_period(20, 0, 1, 10, 0, 0);
    check("R4", "sym h=2 d=1 w=10", int'(last_sym), 3'b010);
    // R3 boundary: cal=7 (h=8), d=8 w=24 -> 3'b101; w=23 -> 3'b100
    cal_i = 3'd7;
    run_period(40, 0, 8, 24, 0, 0);
    check("R3", "sym h=8 w=24", int'(last_sym), 3'b101);
    run_period(40, 0, 8, 23, 0, 0);
    check("R3", "sym h=8 w=23", int'(last_sym), 3'b100);

    // R6: empty period
    cal_i = 3'd1;
    e0 = dut_ecnt;
    run_period(15, 0, 0, 0, 0, 0);
    run_period(15, 0, 2, 4, 0, 0);
    check("R6", "missing pulse err", dut_ecnt - e0, 1);

    // R7: second pulse
    v0 = dut_vcnt; e0 = dut_ecnt;
    run_period(25, 0, 1, 4, 8, 3);
    check("R7", "one valid for two pulses", dut_vcnt - v0, 1);
    check("R7", "second pulse err", dut_ecnt - e0, 1);

    // R8: pulse overruns into next period
    v0 = dut_vcnt; e0 = dut_ecnt;
    run_period(10, 0, 6, 4, 0, 0);
    run_period(12, 3, 0, 0, 0, 0);
    check("R8", "no valid for overrun", dut_vcnt - v0, 0);
    check("R8", "overrun err", dut_ecnt - e0, 1);
    run_period(12, 0, 2, 3, 0, 0);  // closes the empty period: R6 err
    check("R8", "follow-on missing err", dut_ecnt - e0, 2);

    // random periods
    hold = 0;
    for (int n = 0; n < 200; n++) begin
      int h, mode, d1, w1, d2, w2, p, nxt;
      if (hold == 0) cal_i = 3'($urandom % 8);
      h = int'(cal_i) + 1;
      mode = $urandom % 10;
      d1 = (hold > 0 ? hold + 1 : 0) + int'($urandom % (2 * h + 1));
      w1 = 1 + int'($urandom % (8 * h));
      d2 = 0; w2 = 0; nxt = 0;
      if (mode == 0) begin
        w1 = 0;
        p = d1 + 1 + int'($urandom % 8);
      end else if (mode == 1) begin
        d2 = d1 + w1 + 1 + int'($urandom % 5);
        w2 = 1 + int'($urandom % 4);
        p = d2 + w2 + 1 + int'($urandom % 6);
      end else if (mode == 2) begin
        nxt = 1 + int'($urandom % 5);
        p = d1 + 2 + int'($urandom % 5);
        w1 = p - d1 + nxt;
      end else begin
        p = d1 + w1 + 1 + int'($urandom % 8);
      end
      run_period(p, hold, d1, w1, d2, w2);
      hold = nxt;
    end
    run_period(20, hold, hold + 2, 3, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule